// File: doc/BRIEF.md
# Picture-Bus Bank Mapper

This block translates the upper bits of a cartridge picture-bus address into an 8-bit bank number and picks which memory answers the access. Pattern accesses always go to the character ROM. Nametable accesses go either to the console's internal nametable RAM or to the character ROM. Eight 8-bit bank registers and one 8-bit control register hold the mapping. A CPU-side write port loads them, one register per clock.

The translation from `ppu_addr_hi` (picture A13..A10) to `bank_out` and the two active-low chip enables is purely combinational from the stored registers. Only the register file is clocked. The control register selects the following:
- one of four banking modes;
- the nametable mirroring arrangement;
- the nametable source;
- whether A10 replaces bit 0 of the bank inside 2KB windows.

It also carries an active-high save-RAM enable, which is exported directly.

Top module: `ppu_bank_mapper`

## Requirements
- R1: After synchronous reset, all bank registers and the control register are zero. Every pattern window therefore yields bank 0x00 from ROM, every nametable window yields bank 0x00 from RAM, and `sram_en` is 0.
- R2: A write with `cpu_we`=1 loads bank register k (k=0..3) at address 0xD000+k, bank register k (k=4..7) at 0xE000+k-4, and the control register at 0xB003. A write to any other address changes no output.
- R3: With control bits 1:0 = 0, the pattern window w (picture A12..A10 = w, A13 = 0) outputs bank register w.
- R4: With control bits 1:0 = 1, pattern window w outputs register w>>1, which forms a 2KB window. Nametable window n (A11..A10 = n, A13 = 1) outputs register 4+n.
- R5: With control bits 1:0 = 2 or 3, pattern windows 0..3 output registers 0..3 as 1KB windows. Pattern windows 4..7 output register 4+((w-4)>>1) as 2KB windows.
- R6: In modes 0, 2 and 3, a nametable window takes its bank from register 6 or register 7, chosen by control bit 2:
  - bit 2 = 0: windows 0 and 1 use register 6, and windows 2 and 3 use register 7;
  - bit 2 = 1: even windows use register 6, and odd windows use register 7.

  Control bit 3 has no effect.
- R7: When control bit 5 = 1, a 2KB window outputs its register with bit 0 replaced by A10. When bit 5 = 0, it outputs the register unchanged in both halves. 1KB windows and nametable windows are never altered by bit 5.
- R8: `rom_ce_n` and `ram_ce_n` are always complementary. Pattern accesses select ROM (`rom_ce_n`=0). Nametable accesses select RAM when control bit 4 = 0 and ROM when control bit 4 = 1.
- R9: Picture addresses 0x3000..0x3FFF (A13 = 1, A12 = 1) give the same result as the matching address in 0x2000..0x2FFF.
- R10: `sram_en` equals control register bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr_hi | input | 4 | Picture address bits A13..A10 |
| bank_out | output | 8 | Selected 1KB bank number |
| rom_ce_n | output | 1 | Character ROM enable, active low |
| ram_ce_n | output | 1 | Internal nametable RAM enable, active low |
| sram_en | output | 1 | Save-RAM enable, active high |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before any write. They also assume that `ppu_addr_hi`, `cpu_addr` and `cpu_wdata` are stable around each rising edge, because the write-capture and output checks compare values one edge apart. The stimulus meets these conditions. It changes every input one nanosecond after a rising edge, starts with a reset of several cycles, and samples the combinational outputs at the falling edge. It sweeps all 64 combinations of control bits 5..0 over all 16 picture windows, including the mirrored 0x3000 range.

// File: rtl/ppu_map_pkg.sv
package ppu_map_pkg;

    parameter int BANK_W    = 8;
    parameter int NUM_BANKS = 8;
    localparam int IDX_W    = $clog2(NUM_BANKS);

    typedef enum logic [1:0] {
        MAP_1K      = 2'd0,
        MAP_2K_ALL  = 2'd1,
        MAP_SPLIT_A = 2'd2,
        MAP_SPLIT_B = 2'd3
    } bank_mode_e;

    // Decoded view of the used control bits
    typedef struct packed {
        logic       sram_en;
        logic       a10_sub;
        logic       nt_rom;
        logic       mirror_alt;
        bank_mode_e mode;
    } map_ctrl_t;

    // Which register serves the current access, and how
    typedef struct packed {
        logic             is_nt;
        logic             wide;
        logic [IDX_W-1:0] reg_idx;
    } route_t;

    function automatic map_ctrl_t decode_ctrl(input logic [7:0] raw);
        map_ctrl_t c;
        c.mode       = bank_mode_e'(raw[1:0]);
        c.mirror_alt = raw[2];
        c.nt_rom     = raw[4];
        c.a10_sub    = raw[5];
        c.sram_en    = raw[7];
        return c;
    endfunction

endpackage

// File: rtl/ppu_map_regs.sv
module ppu_map_regs
    import ppu_map_pkg::*;
#(
    parameter logic [15:0] LO_BASE   = 16'hD000,
    parameter logic [15:0] HI_BASE   = 16'hE000,
    parameter logic [15:0] CTRL_ADDR = 16'hB003
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cpu_we,
    input  logic [15:0]                        cpu_addr,
    input  logic [7:0]                         cpu_wdata,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]   bank_regs,
    output logic [7:0]                         ctrl_raw
);

    localparam int GROUP = NUM_BANKS / 2;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
            localparam logic [15:0] BASE = (gi < GROUP) ? LO_BASE : HI_BASE;
            localparam logic [15:0] ADDR = BASE + 16'(gi % GROUP);
            always_ff @(posedge clk) begin
                if (rst)
                    bank_regs[gi] <= '0;
                else if (cpu_we && cpu_addr == ADDR)
                    bank_regs[gi] <= cpu_wdata[BANK_W-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_raw <= '0;
        else if (cpu_we && cpu_addr == CTRL_ADDR)
            ctrl_raw <= cpu_wdata;
    end

    AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == CTRL_ADDR) |=> ctrl_raw == $past(cpu_wdata)); // R2

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cpu_we && cpu_addr == CTRL_ADDR) |=> $stable(ctrl_raw)); // R2

endmodule

// File: rtl/ppu_map_route.sv
module ppu_map_route
    import ppu_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] ppu_addr_hi,
    input  map_ctrl_t  ctrl,
    output route_t     route
);

    logic [2:0] win;
    logic       in_nt;

    assign win   = ppu_addr_hi[2:0];
    assign in_nt = ppu_addr_hi[3];

    always_comb begin
        route.is_nt   = in_nt;
        route.wide    = 1'b0;
        route.reg_idx = '0;
        if (!in_nt) begin
            unique case (ctrl.mode)
                MAP_1K: begin
                    route.reg_idx = IDX_W'(win);
                end
                MAP_2K_ALL: begin
                    route.reg_idx = IDX_W'(win[2:1]);
                    route.wide    = 1'b1;
                end
                default: begin
                    if (!win[2]) begin
                        route.reg_idx = IDX_W'(win);
                    end else begin
                        route.reg_idx = IDX_W'({2'b10, win[1]});
                        route.wide    = 1'b1;
                    end
                end
            endcase
        end else begin
            // A12 is ignored here, which mirrors 0x3000 onto 0x2000
            if (ctrl.mode == MAP_2K_ALL)
                route.reg_idx = IDX_W'({1'b1, ppu_addr_hi[1:0]});
            else if (ctrl.mirror_alt)
                route.reg_idx = IDX_W'({2'b11, ppu_addr_hi[0]});
            else
                route.reg_idx = IDX_W'({2'b11, ppu_addr_hi[1]});
        end
    end

    AST_SPLIT_PATTERN_LOW: assert property (@(posedge clk) disable iff (rst)
        (!in_nt && ctrl.mode != MAP_1K) |-> route.reg_idx < IDX_W'(6)); // R5

    AST_NT_NEVER_WIDE: assert property (@(posedge clk) disable iff (rst)
        in_nt |-> !route.wide); // R7

endmodule

// File: rtl/ppu_map_bank.sv
module ppu_map_bank
    import ppu_map_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_regs,
    input  route_t                           route,
    input  logic                             a10,
    input  logic                             a10_sub,
    output logic [BANK_W-1:0]                bank
);

    logic [BANK_W-1:0] base;

    assign base = bank_regs[route.reg_idx];

    always_comb begin
        if (route.wide && a10_sub)
            bank = {base[BANK_W-1:1], a10};
        else
            bank = base;
    end

    AST_HALF_FOLLOWS_A10: assert property (@(posedge clk) disable iff (rst)
        (route.wide && a10_sub) |-> bank[0] == a10); // R7

    AST_UPPER_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
        route.wide |-> bank[BANK_W-1:1] == bank_regs[route.reg_idx][BANK_W-1:1]); // R7

endmodule

// File: rtl/ppu_bank_mapper.sv
module ppu_bank_mapper
    import ppu_map_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic [3:0]  ppu_addr_hi,
    output logic [7:0]  bank_out,
    output logic        rom_ce_n,
    output logic        ram_ce_n,
    output logic        sram_en
);

    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_regs;
    logic [7:0]                       ctrl_raw;
    map_ctrl_t                        ctrl;
    route_t                           route;
    logic                             unused_ctrl_bits;

    ppu_map_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .bank_regs (bank_regs),
        .ctrl_raw  (ctrl_raw)
    );

    assign ctrl             = decode_ctrl(ctrl_raw);
    assign unused_ctrl_bits = ^{ctrl_raw[6], ctrl_raw[3]};

    ppu_map_route u_route (
        .clk         (clk),
        .rst         (rst),
        .ppu_addr_hi (ppu_addr_hi),
        .ctrl        (ctrl),
        .route       (route)
    );

    ppu_map_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .bank_regs (bank_regs),
        .route     (route),
        .a10       (ppu_addr_hi[0]),
        .a10_sub   (ctrl.a10_sub),
        .bank      (bank_out)
    );

    // Nametable from RAM unless the ROM source bit is set
    assign ram_ce_n = !(route.is_nt && !ctrl.nt_rom);
    assign rom_ce_n = !ram_ce_n;
    assign sram_en  = ctrl.sram_en;

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $countones({rom_ce_n, ram_ce_n}) == 1); // R8

    AST_PATTERN_FROM_ROM: assert property (@(posedge clk) disable iff (rst)
        !ppu_addr_hi[3] |-> (!rom_ce_n && ram_ce_n)); // R8

    AST_SRAM_TRACKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == 16'hB003) |=> sram_en == $past(cpu_wdata[7])); // R10

endmodule

// File: tb/sim_ppu_bank_mapper.sv
`timescale 1ns/1ps
module sim_ppu_bank_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [3:0]  ppu_addr_hi = '0;
    logic [7:0]  bank_out;
    logic        rom_ce_n;
    logic        ram_ce_n;
    logic        sram_en;

    always #4 clk = ~clk;

    ppu_bank_mapper u0 (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .ppu_addr_hi(ppu_addr_hi), .bank_out(bank_out),
        .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n), .sram_en(sram_en)
    );

    typedef struct packed {
        logic [7:0] bank;
        logic       rom_n;
        logic       ram_n;
        logic       sram;
    } exp_t;

    exp_t        exp_q[$];
    string       tag_q[$];
    logic [7:0]  mdl_regs [8];
    logic [7:0]  mdl_ctrl;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    string       cur_tag;

    function automatic exp_t model(input logic [3:0] a);
        exp_t       e;
        logic [7:0] b;
        logic       wide;
        int         w;
        int         n;
        wide   = 0;
        e.sram = mdl_ctrl[7];
        w      = int'(a[2:0]);
        n      = int'(a[1:0]);
        if (!a[3]) begin
            e.rom_n = 1'b0;
            e.ram_n = 1'b1;
            if (mdl_ctrl[1:0] == 2'd0) begin
                b = mdl_regs[w]; cur_tag = "R3";
            end else if (mdl_ctrl[1:0] == 2'd1) begin
                b = mdl_regs[w / 2]; wide = 1; cur_tag = "R4";
            end else begin
                cur_tag = "R5";
                if (w < 4) b = mdl_regs[w];
                else begin b = mdl_regs[4 + (w - 4) / 2]; wide = 1; end
            end
            if (wide && mdl_ctrl[5]) begin
                b[0] = a[0]; cur_tag = "R7";
            end
        end else begin
            e.rom_n = ~mdl_ctrl[4];
            e.ram_n = mdl_ctrl[4];
            if (mdl_ctrl[1:0] == 2'd1) begin
                b = mdl_regs[4 + n]; cur_tag = "R4";
            end else begin
                cur_tag = "R6";
                if (mdl_ctrl[2]) b = (n % 2 == 0) ? mdl_regs[6] : mdl_regs[7];
                else             b = (n < 2)      ? mdl_regs[6] : mdl_regs[7];
            end
            if (mdl_ctrl[4]) cur_tag = "R8";
            if (a[2])        cur_tag = "R9";
        end
        e.bank = b;
        return e;
    endfunction

    // Driver side
    task automatic cpu_write(input logic [15:0] addr, input logic [7:0] data);
        @(posedge clk); #1;
        cpu_we = 1'b1; cpu_addr = addr; cpu_wdata = data;
        @(posedge clk); #1;
        cpu_we = 1'b0;
        if (addr >= 16'hD000 && addr <= 16'hD003) mdl_regs[addr - 16'hD000] = data;
        if (addr >= 16'hE000 && addr <= 16'hE003) mdl_regs[addr - 16'hE000 + 4] = data;
        if (addr == 16'hB003) mdl_ctrl = data;
    endtask

    task automatic probe(input logic [3:0] a, input string force_tag);
        exp_t e;
        @(posedge clk); #1;
        ppu_addr_hi = a;
        e = model(a);
        exp_q.push_back(e);
        tag_q.push_back(force_tag == "" ? cur_tag : force_tag);
    endtask

    task automatic sweep_windows(input string force_tag);
        for (int a = 0; a < 16; a++) probe(4'(a), force_tag);
    endtask

    // Monitor side
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bank_out !== e.bank || rom_ce_n !== e.rom_n ||
                ram_ce_n !== e.ram_n || sram_en !== e.sram) begin
                fails++;
                $display("FAIL %s addr_hi=%h ctrl=%h: got bank=%h rom_n=%b ram_n=%b sram=%b, expected bank=%h rom_n=%b ram_n=%b sram=%b",
                         t, ppu_addr_hi, mdl_ctrl, bank_out, rom_ce_n, ram_ce_n, sram_en,
                         e.bank, e.rom_n, e.ram_n, e.sram);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mdl_regs[i] = 8'h00;
        mdl_ctrl = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state across every window
        sweep_windows("R1");

        // R2: load the bank registers, then confirm with mode 0 sweep
        cpu_write(16'hD000, 8'h01); cpu_write(16'hD001, 8'h08);
        cpu_write(16'hD002, 8'h10); cpu_write(16'hD003, 8'h19);
        cpu_write(16'hE000, 8'h20); cpu_write(16'hE001, 8'h29);
        cpu_write(16'hE002, 8'h31); cpu_write(16'hE003, 8'h38);
        sweep_windows("R2");

        // R2: writes to neighbouring addresses must not change anything
        cpu_write(16'hD004, 8'hAA);
        cpu_write(16'hE004, 8'h55);
        cpu_write(16'hB002, 8'hFF);
        cpu_write(16'hC003, 8'hB7);
        sweep_windows("R2");

        // R3..R9: every control value of bits 5..0 over all windows
        for (int c = 0; c < 64; c++) begin
            cpu_write(16'hB003, 8'(c));
            sweep_windows("");
        end

        // R10: save-RAM enable, with unused bits 3 and 6 also set (R6)
        cpu_write(16'hB003, 8'h80);
        sweep_windows("R10");
        cpu_write(16'hB003, 8'hCC);
        sweep_windows("R10");
        cpu_write(16'hB003, 8'h44);
        sweep_windows("R10");

        // R7: even register values make the A10 substitution visible
        cpu_write(16'hD000, 8'h42);
        cpu_write(16'hE001, 8'h7E);
        cpu_write(16'hB003, 8'h21);
        sweep_windows("R7");
        cpu_write(16'hB003, 8'h22);
        sweep_windows("R7");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule